// File: doc/BRIEF.md
# Shift, Rotate and Step Unit

This block performs the single-operand byte transforms of an 8-bit accumulator processor: shift left, logical shift right, rotate left and rotate right through the carry flag, and add or subtract one. A start strobe captures an operation code, an 8-bit operand and the present carry flag. The result and the updated carry, zero and negative flags appear one cycle later, together with a one-cycle done pulse.

The same operations serve two operand sources. An operand taken from the accumulator is written back to the accumulator. An operand read from memory is returned as a modified byte, which the surrounding core writes back to the address it was read from. Address generation and the write-back bus cycle are handled outside the block. A mode input records the operand source. It has no effect on the arithmetic, and it is echoed on the outputs so the core knows where the result goes.

Top module: `shrot_unit`

## Requirements
- R1: Shift left (op code 0) produces {operand[6:0],0} and sets carry to operand bit 7.
- R2: Shift right (op code 1) produces {0,operand[7:1]} and sets carry to operand bit 0.
- R3: Rotate left (op code 2) produces {operand[6:0],carry_in} and sets carry to operand bit 7.
- R4: Rotate right (op code 3) produces {carry_in,operand[7:1]} and sets carry to operand bit 0.
- R5: Increment (op code 4) and decrement (op code 5) wrap modulo 256, so 0xFF+1=0x00 and 0x00-1=0xFF, and the output carry equals carry_in.
- R6: For every operation the zero flag is 1 exactly when the result is 0x00, and the negative flag equals result bit 7.
- R7: The memory-mode flag (mem_mode_i=1) gives the same result and flags as accumulator mode and is echoed on mem_wb_o, which tells the core to write the byte back to memory.
- R8: done_o pulses high for exactly one cycle, on the cycle after a start_i cycle. Outputs remain unchanged while start_i is low. Op codes 6 and 7 pass the operand through unchanged and keep the carry.
- R9: After reset the outputs are zero, done_o is low and carry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Captures the operation this cycle |
| op_i | input | 3 | Operation code |
| mem_mode_i | input | 1 | 1 = memory read-modify-write operand |
| operand_i | input | 8 | Source byte |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 8 | Modified byte |
| carry_o | output | 1 | New carry flag |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result bit 7 |
| mem_wb_o | output | 1 | Result goes back to memory |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result, flag and the done pulse is registered once, so each is due on the first rising edge after the edge that sampled start_i. The bench drives its inputs on the falling edge. It lets one rising edge pass and samples the outputs on the next falling edge, which is half a cycle after the edge that updated them. After that sample it checks that done_o has dropped again. It also checks that the outputs hold steady through idle cycles.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned OW = 3;
  typedef enum logic [OW-1:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_ROL = 3'd2,
    OP_ROR = 3'd3,
    OP_INC = 3'd4,
    OP_DEC = 3'd5,
    OP_NP6 = 3'd6,
    OP_NP7 = 3'd7
  } shrot_op_e;
  typedef struct packed {
    logic [DW-1:0] res;
    logic          cy;
  } shrot_out_t;
endpackage

// File: rtl/shrot_shift.sv
module shrot_shift
  import shrot_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [W-1:0] a_i,
  input  logic         cy_i,
  input  logic         left_i,
  input  logic         rot_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  logic fill;
  assign fill = rot_i & cy_i;
  always_comb begin
    if (left_i) begin
      res_o = {a_i[W-2:0], fill};
      cy_o  = a_i[W-1];
    end else begin
      res_o = {fill, a_i[W-1:1]};
      cy_o  = a_i[0];
    end
  end
endmodule

// File: rtl/shrot_step.sv
module shrot_step #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         down_i,
  output logic [W-1:0] res_o
);
  // two's complement -1 is all ones; wraps mod 2^W
  assign res_o = a_i + (down_i ? {W{1'b1}} : W'(1));
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic         mem_mode_i,
  input  logic [W-1:0] operand_i,
  input  logic         carry_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         mem_wb_o,
  output logic         done_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] sh_res, st_res, nx_res;
  logic         sh_cy, nx_cy;
  shrot_op_e    op;
  assign op = shrot_op_e'(op_i);

  shrot_shift #(.W(W)) u_shift (
    .a_i   (operand_i),
    .cy_i  (carry_i),
    .left_i(op == OP_SHL || op == OP_ROL),
    .rot_i (op == OP_ROL || op == OP_ROR),
    .res_o (sh_res),
    .cy_o  (sh_cy)
  );

  shrot_step #(.W(W)) u_step (
    .a_i   (operand_i),
    .down_i(op == OP_DEC),
    .res_o (st_res)
  );

  always_comb begin
    unique case (op)
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin nx_res = sh_res;    nx_cy = sh_cy;   end
      OP_INC, OP_DEC:                 begin nx_res = st_res;    nx_cy = carry_i; end
      default:                        begin nx_res = operand_i; nx_cy = carry_i; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
      neg_o    <= 1'b0;
      mem_wb_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        result_o <= nx_res;
        carry_o  <= nx_cy;
        zero_o   <= (nx_res == '0);
        neg_o    <= nx_res[MSB];
        mem_wb_o <= mem_mode_i;
      end
    end
  end

  assert_shl_carry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd0) |=> (carry_o == $past(operand_i[MSB])));
  assert_shr_carry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd1) |=> (carry_o == $past(operand_i[0])));
  assert_rol_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd2) |=> (result_o[0] == $past(carry_i)));
  assert_ror_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd3) |=> (result_o[MSB] == $past(carry_i)));
  assert_step_keeps_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (op_i == 3'd4 || op_i == 3'd5)) |=> (carry_o == $past(carry_i)));
  assert_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (zero_o == (result_o == '0)) && (neg_o == result_o[MSB]));
  assert_wb_echo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (mem_wb_o == $past(mem_mode_i)));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o && $stable(result_o) && $stable(carry_o));
endmodule

// File: tb/shrot_unit_tb_top.sv
`timescale 1ns/1ps
module shrot_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] op = '0;
  logic       mm = 1'b0;
  logic [7:0] opd = '0;
  logic       cin = 1'b0;
  logic [7:0] res;
  logic       cy, zf, nf, wb, done;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  shrot_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .mem_mode_i(mm), .operand_i(opd), .carry_i(cin),
    .result_o(res), .carry_o(cy), .zero_o(zf), .neg_o(nf),
    .mem_wb_o(wb), .done_o(done)
  );

  function automatic logic [8:0] model(input logic [2:0] o, input logic [7:0] a, input logic c);
    case (o)
      3'd0: return {a[7], a[6:0], 1'b0};
      3'd1: return {a[0], 1'b0, a[7:1]};
      3'd2: return {a[7], a[6:0], c};
      3'd3: return {a[0], c, a[7:1]};
      3'd4: return {c, a + 8'd1};
      3'd5: return {c, a - 8'd1};
      default: return {c, a};
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [7:0] a, input logic c, input logic m);
    logic [8:0] e;
    e = model(o, a, c);
    @(negedge clk);
    start = 1'b1; op = o; opd = a; cin = c; mm = m;
    @(negedge clk);
    start = 1'b0;
    chk(req_of(o), {23'd0, res, cy}, {23'd0, e[7:0], e[8]});
    chk("R6", {zf, nf}, {e[7:0] == 8'd0, e[7]});
    chk("R7", wb, m);
    chk("R8", done, 1'b1);
    @(negedge clk);
    chk("R8", done, 1'b0);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog act=hang exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #9;
    chk("R9", {res, cy, zf, nf, wb, done}, 13'd0);
    rst_n = 1'b1;
    // directed corners
    run(3'd0, 8'h80, 1'b0, 1'b0); // R1 -> 0, carry 1, zero
    run(3'd1, 8'h01, 1'b1, 1'b1); // R2
    run(3'd2, 8'h80, 1'b1, 1'b0); // R3 -> 01 carry 1
    run(3'd3, 8'h01, 1'b1, 1'b1); // R4 -> 80 carry 1
    run(3'd4, 8'hFF, 1'b1, 1'b0); // R5 wrap up
    run(3'd5, 8'h00, 1'b0, 1'b1); // R5 wrap down
    run(3'd6, 8'h5A, 1'b1, 1'b0); // R8 passthrough
    // R7: same op in both modes gives same result
    for (int i = 0; i < 6; i++) begin
      run(3'(i), 8'hC3, 1'b1, 1'b0);
      run(3'(i), 8'hC3, 1'b1, 1'b1);
    end
    // R8: idle hold
    begin
      logic [7:0] r0; logic c0;
      r0 = res; c0 = cy;
      opd = 8'h11; op = 3'd4;
      repeat (3) @(negedge clk);
      chk("R8", {res, cy, done}, {r0, c0, 1'b0});
    end
    for (int i = 0; i < 300; i++)
      run(3'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule